// File: doc/BRIEF.md
# Interrupt Delivery Throttle

This block limits how often interrupts leave one interrupt group. Pending requests come in from the cause and mask logic. A shared prescaler divides a free-running base tick strobe by a programmable resolution. Interval counters that count in those slower units hold back repeated delivery until the programmed gap has elapsed.

In group mode, all request lines are merged and share one interval, and the block drives a single interrupt line. In vector mode, each vector has its own interval and counter, and the block drives one send strobe per vector. An interval of zero turns throttling off. A flush command releases every held request at once.

Configuration arrives as single-cycle write strobes. Vector intervals are written through an index, and the group interval and the resolution each have their own strobe.

Top module: `irq_moderator`

## Requirements
- R1: After reset, `vec_send` and `grp_irq` are low and every interval counter is zero, so the first request is delivered without delay.
- R2: With resolution N written to `res_val`, the interval counters decrement once for every N+1 cycles in which `base_tick` is high.
- R3: A write to the resolution (`res_we`) restarts the prescaler count from zero. While it is being written, the prescaler gives no decrement in the following cycle unless the new value is zero.
- R4: In vector mode (`vec_mode`=1), a request on `req[i]` while counter i is zero raises `vec_send[i]` for one cycle, starting one clock later, and loads counter i with the interval of vector i.
- R5: A request that arrives while its counter is nonzero is held. It is delivered one clock after the counter reaches zero. Any number of requests held during one interval produce a single delivery, and a delivery with a nonzero interval is never followed directly by another unless a flush occurs.
- R6: An interval of zero passes every request through, one clock later, in every cycle it is present.
- R7: A flush delivers one clock later every held request and every request present in the flush cycle, then reloads those counters. A counter with nothing to deliver is cleared to zero by a flush.
- R8: A new interval value written to a vector (`vivl_we`, `vivl_idx`) does not change a running counter. It is used at that vector's next reload.
- R9: In group mode (`vec_mode`=0), the OR of all `req` bits drives one counter using the group interval (`givl_we`, `givl_val`) and produces `grp_irq`, while `vec_send` stays zero. In vector mode, `grp_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base time strobe fed to the prescaler |
| vec_mode | input | 1 | 1: per-vector throttling, 0: merged group throttling |
| res_we | input | 1 | Resolution write strobe |
| res_val | input | RES_W | Resolution N (decrement every N+1 base ticks) |
| vivl_we | input | 1 | Vector interval write strobe |
| vivl_idx | input | IDX_W | Vector selected by an interval write |
| vivl_val | input | IVL_W | Vector interval in resolution units, 0 disables |
| givl_we | input | 1 | Group interval write strobe |
| givl_val | input | IVL_W | Group interval in resolution units, 0 disables |
| flush | input | 1 | Release all held requests now |
| req | input | NUM_VEC | Pending interrupt requests per vector |
| vec_send | output | NUM_VEC | One-cycle send strobe per vector |
| grp_irq | output | 1 | One-cycle group interrupt strobe |

## Verification
Every delivery decision is taken at the clock edge that samples the request, flush and counter state, and the strobe is registered there, so each result is due exactly one clock after its stimulus. A held request needs one additional clock after the edge that brings its counter to zero. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each comparison sees the result of exactly one rising edge. Prescaler and reload cases count `base_tick` pulses explicitly before each comparison.

// File: rtl/imod_pkg.sv
package imod_pkg;
    typedef enum logic {
        MODE_GROUP  = 1'b0,
        MODE_VECTOR = 1'b1
    } imod_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/imod_prescale.sv
module imod_prescale #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             res_we,
    input  logic [RES_W-1:0] res_val,
    output logic             dec_tick
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [RES_W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        dec_tick = base_tick && (s_q.cnt == s_q.res);
        if (res_we) begin
            s_d.res = res_val;
            s_d.cnt = '0;
        end else if (base_tick) begin
            s_d.cnt = dec_tick ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/imod_ivl_bank.sv
module imod_ivl_bank #(
    parameter int NV    = 4,
    parameter int IVL_W = 8,
    parameter int IDX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vivl_we,
    input  logic [IDX_W-1:0]         vivl_idx,
    input  logic [IVL_W-1:0]         vivl_val,
    input  logic                     givl_we,
    input  logic [IVL_W-1:0]         givl_val,
    output logic [NV-1:0][IVL_W-1:0] ivl_vec,
    output logic [IVL_W-1:0]         ivl_grp
);
    typedef struct packed {
        logic [NV-1:0][IVL_W-1:0] vec;
        logic [IVL_W-1:0]         grp;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NV; i++) begin
            if (vivl_we && (int'(vivl_idx) == i)) s_d.vec[i] = vivl_val;
        end
        if (givl_we) s_d.grp = givl_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ivl_vec = s_q.vec;
    assign ivl_grp = s_q.grp;
endmodule

// File: rtl/imod_slot.sv
module imod_slot #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             dec_tick,
    input  logic             flush,
    input  logic [IVL_W-1:0] ivl,
    output logic             send
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
        logic             pend;
        logic             send;
    } slot_t;

    slot_t s_d, s_q;
    logic  hit, fire;

    always_comb begin
        s_d  = s_q;
        hit  = req || s_q.pend;
        fire = hit && ((s_q.cnt == '0) || flush);
        s_d.send = fire;
        if (fire) begin
            s_d.cnt  = ivl;
            s_d.pend = 1'b0;
        end else begin
            s_d.pend = hit;
            if (flush)
                s_d.cnt = '0;
            else if (dec_tick && (s_q.cnt != '0))
                s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign send = s_q.send;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import imod_pkg::*;
#(
    parameter int NUM_VEC = 4,
    parameter int RES_W   = 8,
    parameter int IVL_W   = 8,
    localparam int IDX_W  = idx_width(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_tick,
    input  logic               vec_mode,
    input  logic               res_we,
    input  logic [RES_W-1:0]   res_val,
    input  logic               vivl_we,
    input  logic [IDX_W-1:0]   vivl_idx,
    input  logic [IVL_W-1:0]   vivl_val,
    input  logic               givl_we,
    input  logic [IVL_W-1:0]   givl_val,
    input  logic               flush,
    input  logic [NUM_VEC-1:0] req,
    output logic [NUM_VEC-1:0] vec_send,
    output logic               grp_irq
);
    logic                          dec_tick;
    logic [NUM_VEC-1:0][IVL_W-1:0] ivl_vec;
    logic [IVL_W-1:0]              ivl_grp;
    logic [NUM_VEC-1:0]            vreq;
    logic                          greq;
    imod_mode_e                    mode;

    assign mode = imod_mode_e'(vec_mode);
    assign vreq = (mode == MODE_VECTOR) ? req : '0;
    assign greq = (mode == MODE_GROUP) && (|req);

    imod_prescale #(.RES_W(RES_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .res_we    (res_we),
        .res_val   (res_val),
        .dec_tick  (dec_tick)
    );

    imod_ivl_bank #(.NV(NUM_VEC), .IVL_W(IVL_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .vivl_we  (vivl_we),
        .vivl_idx (vivl_idx),
        .vivl_val (vivl_val),
        .givl_we  (givl_we),
        .givl_val (givl_val),
        .ivl_vec  (ivl_vec),
        .ivl_grp  (ivl_grp)
    );

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        imod_slot #(.IVL_W(IVL_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (vreq[g]),
            .dec_tick (dec_tick),
            .flush    (flush),
            .ivl      (ivl_vec[g]),
            .send     (vec_send[g])
        );
    end

    imod_slot #(.IVL_W(IVL_W)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (greq),
        .dec_tick (dec_tick),
        .flush    (flush),
        .ivl      (ivl_grp),
        .send     (grp_irq)
    );
endmodule

// File: rtl/imod_chk.sv
module imod_chk #(
    parameter int NV    = 4,
    parameter int RES_W = 8,
    parameter int IVL_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vec_mode,
    input logic                     flush,
    input logic [NV-1:0]            req,
    input logic                     res_we,
    input logic [RES_W-1:0]         res_val,
    input logic                     dec_tick,
    input logic [NV-1:0][IVL_W-1:0] ivl_vec,
    input logic [NV-1:0]            vec_send,
    input logic                     grp_irq
);
    p_res_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && (res_val != '0)) |=> !dec_tick);

    p_group_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_mode |=> (vec_send == '0));

    p_vector_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_mode |=> !grp_irq);

    for (genvar i = 0; i < NV; i++) begin : g_chk
        p_flush_delivers_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_mode && flush && req[i]) |=> vec_send[i]);

        p_hold_after_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_send[i] && ($past(ivl_vec[i]) != '0) && !flush) |=> !vec_send[i]);
    end
endmodule

bind irq_moderator imod_chk #(.NV(NUM_VEC), .RES_W(RES_W), .IVL_W(IVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_mode (vec_mode),
    .flush    (flush),
    .req      (req),
    .res_we   (res_we),
    .res_val  (res_val),
    .dec_tick (dec_tick),
    .ivl_vec  (ivl_vec),
    .vec_send (vec_send),
    .grp_irq  (grp_irq)
);

// File: tb/sim_irq_moderator.sv
module sim_irq_moderator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       vec_mode = 1'b1;
    logic       res_we = 1'b0;
    logic [7:0] res_val = '0;
    logic       vivl_we = 1'b0;
    logic [1:0] vivl_idx = '0;
    logic [7:0] vivl_val = '0;
    logic       givl_we = 1'b0;
    logic [7:0] givl_val = '0;
    logic       flush = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] vec_send;
    logic       grp_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_moderator u0 (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .vec_mode(vec_mode),
        .res_we(res_we), .res_val(res_val), .vivl_we(vivl_we), .vivl_idx(vivl_idx),
        .vivl_val(vivl_val), .givl_we(givl_we), .givl_val(givl_val), .flush(flush),
        .req(req), .vec_send(vec_send), .grp_irq(grp_irq)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic       tk;
        logic       fl;
        logic [3:0] ex;
    } step_t;

    // vector mode, resolution 0, intervals v0=0 v1=2 v2=3 v3=1
    localparam step_t TBL [12] = '{
        '{4'b0010, 1'b0, 1'b0, 4'b0010},  // R4 idle counter: immediate
        '{4'b0010, 1'b1, 1'b0, 4'b0000},  // R5 held, count 2->1
        '{4'b0010, 1'b0, 1'b0, 4'b0000},  // R5 merged
        '{4'b0000, 1'b1, 1'b0, 4'b0000},  // R5 count 1->0
        '{4'b0000, 1'b0, 1'b0, 4'b0010},  // R5 single delivery
        '{4'b0001, 1'b0, 1'b0, 4'b0001},  // R6 zero interval
        '{4'b0001, 1'b0, 1'b0, 4'b0001},  // R6 again next cycle
        '{4'b0100, 1'b0, 1'b0, 4'b0100},  // R4 vector 2 loads 3
        '{4'b0110, 1'b0, 1'b0, 4'b0000},  // R5 both held
        '{4'b0000, 1'b0, 1'b1, 4'b0110},  // R7 flush releases both
        '{4'b0000, 1'b0, 1'b1, 4'b0000},  // R7 flush clears counters
        '{4'b0110, 1'b0, 1'b0, 4'b0110}   // R7 cleared: immediate
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] r, input logic t, input logic f);
        req = r; base_tick = t; flush = f;
        @(negedge clk);
        req = '0; base_tick = 1'b0; flush = 1'b0;
    endtask

    task automatic wr_res(input logic [7:0] v);
        res_we = 1'b1; res_val = v;
        @(negedge clk);
        res_we = 1'b0;
    endtask

    task automatic wr_vivl(input logic [1:0] i, input logic [7:0] v);
        vivl_we = 1'b1; vivl_idx = i; vivl_val = v;
        @(negedge clk);
        vivl_we = 1'b0;
    endtask

    task automatic wr_givl(input logic [7:0] v);
        givl_we = 1'b1; givl_val = v;
        @(negedge clk);
        givl_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vec_send after reset", 32'(vec_send), 32'h0);
        chk("R1 grp_irq after reset", 32'(grp_irq), 32'h0);

        wr_res(8'd0);
        wr_vivl(2'd0, 8'd0);
        wr_vivl(2'd1, 8'd2);
        wr_vivl(2'd2, 8'd3);
        wr_vivl(2'd3, 8'd1);

        for (int k = 0; k < 12; k++) begin
            cyc(TBL[k].rq, TBL[k].tk, TBL[k].fl);
            chk($sformatf("R4/R5/R6/R7 table row %0d", k), 32'(vec_send), 32'(TBL[k].ex));
            chk($sformatf("R9 grp_irq quiet row %0d", k), 32'(grp_irq), 32'h0);
        end

        // R8: vector 2 counter holds 3; new interval 1 only at next reload
        wr_vivl(2'd2, 8'd1);
        cyc(4'b0100, 1'b0, 1'b0);
        chk("R8 held after rewrite", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b1, 1'b0);
        cyc(4'b0000, 1'b1, 1'b0);
        chk("R8 old count still running", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b1, 1'b0);
        chk("R8 reaches zero", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b0, 1'b0);
        chk("R8 delivery after old interval", 32'(vec_send), 32'h4);
        cyc(4'b0100, 1'b0, 1'b0);
        chk("R8 held with new interval", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b1, 1'b0);
        cyc(4'b0000, 1'b0, 1'b0);
        chk("R8 new interval of 1 used", 32'(vec_send), 32'h4);

        // R2/R3: resolution 2, vector 3 interval 1
        wr_res(8'd2);
        cyc(4'b1000, 1'b0, 1'b0);
        chk("R2 first delivery", 32'(vec_send), 32'h8);
        cyc(4'b1000, 1'b0, 1'b0);
        chk("R2 held", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b1, 1'b0);
        cyc(4'b0000, 1'b1, 1'b0);
        wr_res(8'd2);
        cyc(4'b0000, 1'b1, 1'b0);
        cyc(4'b0000, 1'b1, 1'b0);
        chk("R3 prescaler restarted", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b1, 1'b0);
        chk("R2 third tick decrements", 32'(vec_send), 32'h0);
        cyc(4'b0000, 1'b0, 1'b0);
        chk("R2 delivery after N+1 ticks", 32'(vec_send), 32'h8);

        // R9: group mode, interval 2, resolution 0
        vec_mode = 1'b0;
        wr_res(8'd0);
        wr_givl(8'd2);
        cyc(4'b1000, 1'b0, 1'b0);
        chk("R9 group immediate", 32'(grp_irq), 32'h1);
        chk("R9 vec_send quiet in group mode", 32'(vec_send), 32'h0);
        cyc(4'b0001, 1'b0, 1'b0);
        chk("R9 other line shares group counter", 32'(grp_irq), 32'h0);
        cyc(4'b0000, 1'b1, 1'b0);
        cyc(4'b0000, 1'b1, 1'b0);
        chk("R9 group count reaches zero", 32'(grp_irq), 32'h0);
        cyc(4'b0000, 1'b0, 1'b0);
        chk("R9 group held delivery", 32'(grp_irq), 32'h1);
        chk("R9 vec_send still quiet", 32'(vec_send), 32'h0);
        cyc(4'b0010, 1'b0, 1'b0);
        chk("R7 group held before flush", 32'(grp_irq), 32'h0);
        cyc(4'b0000, 1'b0, 1'b1);
        chk("R7 group flush delivers", 32'(grp_irq), 32'h1);
        wr_givl(8'd0);
        cyc(4'b0000, 1'b0, 1'b1);
        chk("R7 empty flush no strobe", 32'(grp_irq), 32'h0);
        cyc(4'b0100, 1'b0, 1'b0);
        chk("R6 group zero interval", 32'(grp_irq), 32'h1);
        cyc(4'b0100, 1'b0, 1'b0);
        chk("R6 group zero interval repeat", 32'(grp_irq), 32'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule